// File: doc/BRIEF.md
# Dual-Copy Rounding Weight Updater

This block is a weight store for training on hardware with narrow weights. Each address holds two versions of one weight. The first is a hidden accumulator with 16 fractional bits. The second is a coarse fixed-point code with `INT_BITS` integer magnitude bits, a sign bit and `FRAC_BITS` fractional bits. Forward computation reads only the coarse code, through a synchronous read port. Learning writes only the accumulator, through an update port that carries an address and a signed delta. After every update the coarse code is derived again from the accumulator. Because of this, many deltas that are each too small to move the coarse code still add up until the rounded value changes.

A per-update mode bit selects a second policy, direct rounding. In that mode the delta is added to the coarse value itself and the sum is rounded straight back. The accumulator is left alone, so a delta below half a coarse step is lost.

Updates go through three stages: operand read, add/clamp/round, and write. An address can be updated in any cycle, including consecutive cycles to the same address. Results still in flight are forwarded, so every delta is applied.

Top module: `dual_copy_weight_updater`

## Requirements
- R1: A synchronous reset clears every accumulator and every coarse code to zero and drops any update in flight. After reset, reads return 0 and accumulation starts from zero.
- R2: With `upd_iter`=0, the delta (16 fractional bits) is added to the accumulator of `upd_addr`. The coarse code is then derived from the new accumulator, so deltas that are each below half a coarse step still change the code once their sum crosses the rounding point.
- R3: The accumulator sum is clamped to the range -2^INT_BITS ... +2^INT_BITS. Later deltas act on the clamped value.
- R4: Rounding goes to FRAC_BITS fractional bits, with ties rounded away from zero. `rd_data` is a two's-complement code of INT_BITS+FRAC_BITS+1 bits whose value is code·2^-FRAC_BITS.
- R5: A rounded value of +2^INT_BITS saturates to the largest code (63 by default). The value -2^INT_BITS is stored exactly (code -64 by default).
- R6: With `upd_iter`=1, the delta is added to the current coarse value and the result is clamped and rounded back. A delta below half a step has no effect, and the accumulator of that address is not changed.
- R7: An update sampled at clock edge E is written at edge E+2. A read sampled after that edge returns the new code.
- R8: Updates to the same address that are one, two or three cycles apart all take effect. No delta is lost, and this holds when the two modes are mixed.
- R9: `rd_data` updates at the edge after `rd_addr` is sampled. If that edge also writes the same address, `rd_data` returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Update request this cycle |
| upd_iter | input | 1 | 0: accumulate in hidden copy, 1: direct rounding |
| upd_addr | input | ADDR_W | Weight address to update |
| upd_delta | input | HP_W | Signed delta, 16 fractional bits |
| rd_addr | input | ADDR_W | Weight address to read |
| rd_data | output | LP_W | Coarse weight code, registered |

## Verification
Two pairs of events can land on the same address in the same cycle. The first pair is the write stage committing a result and the read port sampling that address. The bench provokes this by setting `rd_addr` to the address that is updating, exactly in the cycle before the commit edge. It then expects the old code first and the new code one cycle later. The second pair is a new update entering the pipeline while an older update to the same address is still in the compute or write stage. The bench sends bursts spaced one, two and three cycles apart, including a mix of the two modes. It judges the result from the final code, worked out by hand from the sum of the deltas.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic {
        MODE_ACCUM = 1'b0,
        MODE_ITER  = 1'b1
    } upd_mode_e;

endpackage

// File: rtl/dcw_quant.sv
module dcw_quant #(
    parameter  int INT_BITS  = 2,
    parameter  int FRAC_BITS = 4,
    parameter  int HP_FRAC   = 16,
    localparam int HP_W      = INT_BITS + HP_FRAC + 2,
    localparam int LP_W      = INT_BITS + FRAC_BITS + 1
) (
    input  logic signed [HP_W:0]   sum_i,
    output logic signed [HP_W-1:0] wh_o,
    output logic signed [LP_W-1:0] wl_o
);
    localparam int SH = HP_FRAC - FRAC_BITS;
    localparam logic signed [HP_W:0] LIM_P =
        (HP_W+1)'(longint'(1) << (INT_BITS + HP_FRAC));
    localparam logic signed [HP_W:0] NLIM_P = -LIM_P;
    localparam logic [HP_W-1:0] TOP_MAG = HP_W'(longint'(1) << (INT_BITS + FRAC_BITS));
    localparam logic signed [LP_W-1:0] LP_MAX = {1'b0, {(LP_W-1){1'b1}}};

    logic signed [HP_W:0] clamped;
    logic                 neg;
    logic [HP_W-1:0]      mag;
    logic [HP_W-1:0]      rmag;

    // saturate the wide sum to the format range
    always_comb begin
        if (sum_i >= LIM_P)       clamped = LIM_P;
        else if (sum_i <= NLIM_P) clamped = NLIM_P;
        else                      clamped = sum_i;
        neg  = clamped[HP_W];
        mag  = neg ? HP_W'(-clamped) : HP_W'(clamped);
        wh_o = clamped[HP_W-1:0];
    end

    // magnitude rounding: ties go away from zero
    generate
        if (SH > 0) begin : g_round
            localparam logic [HP_W-1:0] HALF = HP_W'(longint'(1) << (SH - 1));
            assign rmag = (mag + HALF) >> SH;
        end else begin : g_pass
            assign rmag = mag;
        end
    endgenerate

    always_comb begin
        if (!neg && rmag >= TOP_MAG) wl_o = LP_MAX;
        else if (neg)                wl_o = -LP_W'(rmag);
        else                         wl_o = LP_W'(rmag);
    end

endmodule

// File: rtl/dcw_array.sv
module dcw_array #(
    parameter  int ADDR_W = 4,
    parameter  int HP_W   = 20,
    parameter  int LP_W   = 7,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     wr_hp_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [HP_W-1:0]   wr_hp,
    input  logic signed [LP_W-1:0]   wr_lp,
    input  logic [ADDR_W-1:0]        lk_addr,
    output logic signed [HP_W-1:0]   lk_hp,
    output logic signed [LP_W-1:0]   lk_lp,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [LP_W-1:0]   rd_lp
);
    logic signed [HP_W-1:0] hp_q [DEPTH];
    logic signed [HP_W-1:0] hp_d [DEPTH];
    logic signed [LP_W-1:0] lp_q [DEPTH];
    logic signed [LP_W-1:0] lp_d [DEPTH];
    logic signed [LP_W-1:0] rd_q, rd_d;

    always_comb begin
        hp_d = hp_q;
        lp_d = lp_q;
        rd_d = lp_q[rd_addr];            // pre-write contents
        if (wr_en) begin
            lp_d[wr_addr] = wr_lp;
            if (wr_hp_en) hp_d[wr_addr] = wr_hp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hp_q <= '{default: '0};
            lp_q <= '{default: '0};
            rd_q <= '0;
        end else begin
            hp_q <= hp_d;
            lp_q <= lp_d;
            rd_q <= rd_d;
        end
    end

    assign lk_hp = hp_q[lk_addr];
    assign lk_lp = lp_q[lk_addr];
    assign rd_lp = rd_q;

endmodule

// File: rtl/dual_copy_weight_updater.sv
module dual_copy_weight_updater
    import dcw_pkg::*;
#(
    parameter  int ADDR_W    = 4,
    parameter  int INT_BITS  = 2,
    parameter  int FRAC_BITS = 4,
    parameter  int HP_FRAC   = 16,
    localparam int HP_W      = INT_BITS + HP_FRAC + 2,
    localparam int LP_W      = INT_BITS + FRAC_BITS + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd_valid,
    input  logic                   upd_iter,
    input  logic [ADDR_W-1:0]      upd_addr,
    input  logic signed [HP_W-1:0] upd_delta,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic signed [LP_W-1:0] rd_data
);
    localparam int SH       = HP_FRAC - FRAC_BITS;
    localparam int STEP_I   = 1 << SH;
    localparam int HALF_I   = STEP_I / 2;
    localparam int LIM_I    = 1 << (INT_BITS + HP_FRAC);
    localparam int LP_MAX_I = (1 << (INT_BITS + FRAC_BITS)) - 1;

    typedef struct packed {
        logic                   valid;
        upd_mode_e              mode;
        logic [ADDR_W-1:0]      addr;
        logic signed [HP_W-1:0] delta;
        logic signed [HP_W-1:0] wh;
        logic signed [LP_W-1:0] wl;
    } rd_stage_t;

    typedef struct packed {
        logic                   valid;
        upd_mode_e              mode;
        logic [ADDR_W-1:0]      addr;
        logic signed [HP_W-1:0] wh;
        logic signed [LP_W-1:0] wl;
    } wr_stage_t;

    typedef struct packed {
        rd_stage_t s1;
        wr_stage_t s2;
    } pipe_t;

    pipe_t st_d, st_q;

    logic signed [HP_W-1:0] lk_hp, q_wh;
    logic signed [LP_W-1:0] lk_lp, q_wl;
    logic signed [HP_W:0]   operand, sum;
    logic signed [HP_W-1:0] cap_wh, base_wh;
    logic signed [LP_W-1:0] cap_wl, base_wl;
    logic                   fwd_cap, fwd_cmp;

    dcw_array #(.ADDR_W(ADDR_W), .HP_W(HP_W), .LP_W(LP_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (st_q.s2.valid),
        .wr_hp_en (st_q.s2.mode == MODE_ACCUM),
        .wr_addr  (st_q.s2.addr),
        .wr_hp    (st_q.s2.wh),
        .wr_lp    (st_q.s2.wl),
        .lk_addr  (upd_addr),
        .lk_hp    (lk_hp),
        .lk_lp    (lk_lp),
        .rd_addr  (rd_addr),
        .rd_lp    (rd_data)
    );

    dcw_quant #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS), .HP_FRAC(HP_FRAC)) u_quant (
        .sum_i (sum),
        .wh_o  (q_wh),
        .wl_o  (q_wl)
    );

    always_comb begin
        // stage 1 capture: bypass the value about to be committed
        fwd_cap = st_q.s2.valid && (st_q.s2.addr == upd_addr);
        cap_wh  = (fwd_cap && st_q.s2.mode == MODE_ACCUM) ? st_q.s2.wh : lk_hp;
        cap_wl  = fwd_cap ? st_q.s2.wl : lk_lp;

        // stage 2 compute: bypass the immediately preceding result
        fwd_cmp = st_q.s2.valid && (st_q.s2.addr == st_q.s1.addr);
        base_wh = (fwd_cmp && st_q.s2.mode == MODE_ACCUM) ? st_q.s2.wh : st_q.s1.wh;
        base_wl = fwd_cmp ? st_q.s2.wl : st_q.s1.wl;
        operand = (st_q.s1.mode == MODE_ITER) ? ((HP_W+1)'(base_wl) <<< SH)
                                              : (HP_W+1)'(base_wh);
        sum     = operand + (HP_W+1)'(st_q.s1.delta);

        st_d.s1.valid = upd_valid;
        st_d.s1.mode  = upd_iter ? MODE_ITER : MODE_ACCUM;
        st_d.s1.addr  = upd_addr;
        st_d.s1.delta = upd_delta;
        st_d.s1.wh    = cap_wh;
        st_d.s1.wl    = cap_wl;

        st_d.s2.valid = st_q.s1.valid;
        st_d.s2.mode  = st_q.s1.mode;
        st_d.s2.addr  = st_q.s1.addr;
        st_d.s2.wh    = q_wh;
        st_d.s2.wl    = q_wl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3: the value headed for the accumulator never leaves the clamp range
    p_hp_clamped_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.s2.valid |-> (int'(st_q.s2.wh) <= LIM_I && int'(st_q.s2.wh) >= -LIM_I));

    // R4: unsaturated coarse code lies within half a step of the wide value
    p_round_near_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.s2.valid && int'(st_q.s2.wl) != LP_MAX_I) |->
        ((int'(st_q.s2.wh) - int'(st_q.s2.wl) * STEP_I) <= HALF_I &&
         (int'(st_q.s2.wh) - int'(st_q.s2.wl) * STEP_I) >= -HALF_I));

    // R5: wide values at or past the top rounding point give the largest code
    p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.s2.valid && int'(st_q.s2.wh) >= LP_MAX_I * STEP_I + HALF_I) |->
        (int'(st_q.s2.wl) == LP_MAX_I));

    // R7: each captured update reaches the write stage one edge later
    p_pipe_advance_r7: assert property (@(posedge clk) disable iff (rst)
        st_q.s1.valid |=> st_q.s2.valid);

endmodule

// File: tb/test_dual_copy_weight_updater.sv
module test_dual_copy_weight_updater;

    localparam int ADDR_W = 4;
    localparam int HP_W   = 20;
    localparam int LP_W   = 7;
    localparam int NV     = 20;

    // vector table: mode, address, delta (2^-16 units), expected code (2^-4 units), requirement
    localparam int V_IT  [NV] = '{0,0,0,1,1, 0,0,0,0,0, 0,0,0,0,1, 1,1,0,1,1};
    localparam int V_AD  [NV] = '{1,1,1,2,2, 3,4,4,5,5, 6,6,7,7,8, 8,1,1,9,9};
    localparam int V_DL  [NV] = '{4096, 2047, 1, 2047, 2048,
                                  -6144, 524287, -8192, -524288, 4096,
                                  -2048, -2047, 1500, 1500, 1500,
                                  1500, 4096, 0, 524287, 1};
    localparam int V_EX  [NV] = '{1, 1, 2, 0, 1,
                                  -2, 63, 62, -64, -63,
                                  -1, -1, 0, 1, 0,
                                  0, 3, 2, 63, 63};
    // R2 accumulate, R4 ties, R6 direct mode, R3 clamp, R5 saturation
    localparam int V_RQ  [NV] = '{2, 2, 4, 6, 4,
                                  4, 5, 3, 5, 3,
                                  4, 4, 2, 2, 6,
                                  6, 6, 6, 5, 6};

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   upd_valid = 1'b0;
    logic                   upd_iter = 1'b0;
    logic [ADDR_W-1:0]      upd_addr = '0;
    logic signed [HP_W-1:0] upd_delta = '0;
    logic [ADDR_W-1:0]      rd_addr = '0;
    logic signed [LP_W-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dual_copy_weight_updater i_dual_copy_weight_updater (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .upd_iter  (upd_iter),
        .upd_addr  (upd_addr),
        .upd_delta (upd_delta),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int it, input int ad, input int dl);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_iter  = (it != 0);
        upd_addr  = ADDR_W'(ad);
        upd_delta = HP_W'(dl);
    endtask

    task automatic idle();
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic read(input int ad, output int val);
        @(negedge clk);
        rd_addr = ADDR_W'(ad);
        @(negedge clk);
        val = int'(rd_data);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        read(0, v);  check("R1 reset addr0", v, 0);
        read(5, v);  check("R1 reset addr5", v, 0);
        read(15, v); check("R1 reset addr15", v, 0);

        // table walk, one isolated update per vector
        for (int i = 0; i < NV; i++) begin
            put(V_IT[i], V_AD[i], V_DL[i]);
            idle();
            settle();
            read(V_AD[i], v);
            check($sformatf("R%0d vector %0d", V_RQ[i], i), v, V_EX[i]);
        end

        // R8: consecutive cycles, same address
        put(0, 10, 4096); put(0, 10, 4096); put(0, 10, 4096); put(0, 10, 4096);
        idle(); settle();
        read(10, v); check("R8 back-to-back x4", v, 4);

        // R8: two cycles apart, half-step deltas
        put(0, 11, 2048); idle(); put(0, 11, 2048); idle(); put(0, 11, 2048); idle();
        settle();
        read(11, v); check("R8 spacing two", v, 2);

        // R8: three cycles apart
        put(0, 13, 4096); idle(); @(negedge clk); put(0, 13, 4096); idle();
        settle();
        read(13, v); check("R8 spacing three", v, 2);

        // R8/R6: mixed modes back to back; direct update leaves accumulator alone
        put(0, 14, 4096); put(1, 14, 4096); idle(); settle();
        read(14, v); check("R8 mixed modes", v, 2);
        put(0, 14, 0); idle(); settle();
        read(14, v); check("R6 accumulator untouched", v, 1);

        // R6: sub-half deltas back to back in direct mode are lost
        put(1, 15, 2047); put(1, 15, 2047); put(1, 15, 2047); idle(); settle();
        read(15, v); check("R6 direct small deltas", v, 0);

        // R7/R9: read and commit of the same address on one edge
        put(0, 12, 12288);
        idle();                       // capture edge passed
        @(negedge clk);               // compute edge passed
        rd_addr = 4'd12;
        @(negedge clk);               // commit edge passed
        check("R9 read-during-write old", int'(rd_data), 0);
        @(negedge clk);
        check("R7 new value after commit", int'(rd_data), 3);

        // R1: reset drops stored values and an update in flight
        put(0, 3, 4096);
        @(negedge clk);
        upd_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        settle();
        read(3, v); check("R1 in-flight dropped", v, 0);
        read(4, v); check("R1 stored cleared", v, 0);
        put(0, 4, 4096); idle(); settle();
        read(4, v); check("R1 accumulate from zero", v, 1);

        report();
    end

endmodule